// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarms and Stopwatch

This block keeps wall-clock time from a slow reference clock. A prescaler turns the reference clock into a once-per-second advance. Cascaded counters then hold seconds, minutes, hours and the day of the year. The block runs entirely in the reference clock domain.

Two comparators watch the time:
- The first fires at a programmed time of day.
- The second fires at a programmed day and time.

A countdown stopwatch with one-minute resolution signals when it runs out. Every event sets a sticky status bit, and each bit has its own enable. The enabled and pending bits drive per-source interrupt lines and a single wake-up request.

Software reaches the block through a flat write port and a combinational read port. Six word addresses cover the following:
- the time
- the two alarm settings
- the stopwatch
- the interrupt enables
- the interrupt status

Top module: `rtc_core`

## Requirements
- R1: The time advances by one second once every PRESCALE_DIV clock cycles. After a write to the time word, the first advance comes exactly PRESCALE_DIV cycles after that write edge. No advance happens on the write edge itself.
- R2: Seconds and minutes wrap from 59 to 0, hours from 23 to 0, and the day from 364 to 0. Each wrap carries into the next field, so day 364 23:59:59 becomes day 0 00:00:00.
- R3: Status bit 0 sets on every one-second advance. Bit 1 sets when seconds wrap, bit 2 when minutes wrap, and bit 3 when hours wrap (a new day).
- R4: Status bit 4 (alarm one) sets on the advance that makes hours, minutes and seconds equal the alarm-one setting. The day field of that setting is ignored. It sets once per match.
- R5: Status bit 5 (alarm two) sets only on the advance that makes day, hours, minutes and seconds all equal the alarm-two setting.
- R6: A write of N to the stopwatch word loads N and arms the stopwatch. Each seconds wrap decrements it while it is armed. On a seconds wrap with the count at 0, status bit 6 sets and the stopwatch disarms. The stopwatch word reads back the count in bits 15:0 and the armed flag in bit 16.
- R7: Status bits are sticky. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: `irq[i]` is status bit i AND enable bit i. `wake` is high when any `irq` bit is high.
- R9: The word addresses are: time 0, alarm one 1, alarm two 2, stopwatch 3, enable 4, status 5. The time and alarm words place seconds in bits 5:0, minutes in 11:6, hours in 16:12 and day in 25:17. Out-of-range fields written to the time word load as 0.
- R10: After reset, the time, status and enables are zero, and `irq` and `wake` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (nominally 32.768 kHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 7 | Per-source enabled pending interrupts |
| wake | output | 1 | OR of all enabled pending interrupts |

## Verification
The bench drives every field across its wrap at once through the year boundary. A carry chain that is off by one would give day 365 or a stale hour. It counts prescaler cycles exactly around a time write. A prescaler that is not restarted, or that advances on the write edge, would move the seconds a cycle early.

Alarm two is presented with a matching time on the wrong day, where a comparator missing the day field would fire. Alarm one is checked for a single event with its day field deliberately mismatched. The stopwatch is timed to fire on the wrap after reaching zero, not on the wrap that reaches zero. The bench also confirms that clearing one status bit leaves the others set.

// File: rtl/rtc_pkg.sv
// Shared types and constants for the real-time clock.
// Assumes a 32-bit register word and a 365-day year without leap handling.
package rtc_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int N_EV     = 7;
    localparam int SEC_TOP  = 59;
    localparam int MIN_TOP  = 59;
    localparam int HR_TOP   = 23;
    localparam int DAY_TOP  = 364;

    localparam int EV_SEC  = 0;
    localparam int EV_MIN  = 1;
    localparam int EV_HR   = 2;
    localparam int EV_DAY  = 3;
    localparam int EV_AL1  = 4;
    localparam int EV_AL2  = 5;
    localparam int EV_SW   = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_TIME   = 3'd0,
        A_ALM1   = 3'd1,
        A_ALM2   = 3'd2,
        A_SWATCH = 3'd3,
        A_IEN    = 3'd4,
        A_ISTAT  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [8:0] day;
        logic [4:0] hr;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_t;

    localparam int TOD_W = $bits(tod_t);
endpackage

// File: rtl/rtc_prescaler.sv
// Divides the reference clock into a one-cycle tick every DIV cycles.
// Assumes DIV >= 2; restart returns the count to zero.
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count reference cycles, wrapping on the tick or restarting on demand.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (restart || tick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    // R1
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));
endmodule

// File: rtl/rtc_timekeeper.sv
// Holds the calendar time and advances it by one second per adv pulse.
// Assumes load has priority over adv; out-of-range loaded fields become 0.
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic load,
    input  tod_t load_val,
    output tod_t now,
    output tod_t nxt,
    output logic ev_sec,
    output logic ev_min,
    output logic ev_hr,
    output logic ev_day
);
    logic sec_wrap, min_wrap, hr_wrap;
    tod_t clean;

    // Compute the time one second ahead with the carry chain.
    always_comb begin
        sec_wrap = (now.sec == 6'(SEC_TOP));
        min_wrap = sec_wrap && (now.min == 6'(MIN_TOP));
        hr_wrap  = min_wrap && (now.hr == 5'(HR_TOP));
        nxt      = now;
        nxt.sec  = sec_wrap ? '0 : now.sec + 1'b1;
        if (sec_wrap) nxt.min = (now.min == 6'(MIN_TOP)) ? '0 : now.min + 1'b1;
        if (min_wrap) nxt.hr  = (now.hr == 5'(HR_TOP)) ? '0 : now.hr + 1'b1;
        if (hr_wrap)  nxt.day = (now.day == 9'(DAY_TOP)) ? '0 : now.day + 1'b1;
    end

    // Replace out-of-range fields of a software load with zero.
    always_comb begin
        clean     = load_val;
        if (load_val.sec > 6'(SEC_TOP)) clean.sec = '0;
        if (load_val.min > 6'(MIN_TOP)) clean.min = '0;
        if (load_val.hr  > 5'(HR_TOP))  clean.hr  = '0;
        if (load_val.day > 9'(DAY_TOP)) clean.day = '0;
    end

    assign ev_sec = adv;
    assign ev_min = adv && sec_wrap;
    assign ev_hr  = adv && min_wrap;
    assign ev_day = adv && hr_wrap;

    // Register the time: software load first, then the one-second advance.
    always_ff @(posedge clk) begin
        if (!rst_n)    now <= '0;
        else if (load) now <= clean;
        else if (adv)  now <= nxt;
    end

    // R2
    field_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (now.sec <= 6'(SEC_TOP)) && (now.min <= 6'(MIN_TOP)) &&
        (now.hr <= 5'(HR_TOP)) && (now.day <= 9'(DAY_TOP)));

    // R1
    hold_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> (now == $past(now)));
endmodule

// File: rtl/rtc_stopwatch.sv
// Minute-resolution countdown that fires on the minute step after reaching zero.
// Assumes step is a one-cycle pulse on each seconds wrap; load re-arms.
module rtc_stopwatch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         armed,
    output logic         fire
);
    assign fire = step && armed && (count == '0) && !load;

    // Load and arm, decrement each minute, disarm on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            armed <= 1'b0;
        end else if (load) begin
            count <= load_val;
            armed <= 1'b1;
        end else if (step && armed) begin
            if (count == '0) armed <= 1'b0;
            else             count <= count - 1'b1;
        end
    end

    // R6
    disarm_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !armed);
endmodule

// File: rtl/rtc_core.sv
// Real-time clock top: prescaler, calendar counters, two alarms, stopwatch,
// sticky write-1-to-clear status with per-bit enables and a wake-up request.
// Assumes all inputs are synchronous to the reference clock.
module rtc_core
    import rtc_pkg::*;
#(
    parameter int PRESCALE_DIV = 32768,
    parameter int SW_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N_EV-1:0]   irq,
    output logic              wake
);
    reg_addr_e sel;
    logic tick, adv, time_wr, sw_wr, stat_wr;
    tod_t now, nxt, alm1, alm2;
    logic ev_sec, ev_min, ev_hr, ev_day, al1_hit, al2_hit, sw_fire, sw_armed;
    logic [SW_W-1:0] sw_count;
    logic [N_EV-1:0] ien, stat, events;

    assign sel     = reg_addr_e'(addr);
    assign time_wr = wr_en && (sel == A_TIME);
    assign sw_wr   = wr_en && (sel == A_SWATCH);
    assign stat_wr = wr_en && (sel == A_ISTAT);
    assign adv     = tick && !time_wr;

    rtc_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(time_wr), .tick(tick)
    );

    rtc_timekeeper u_tk (
        .clk(clk), .rst_n(rst_n), .adv(adv), .load(time_wr),
        .load_val(tod_t'(wdata[TOD_W-1:0])), .now(now), .nxt(nxt),
        .ev_sec(ev_sec), .ev_min(ev_min), .ev_hr(ev_hr), .ev_day(ev_day)
    );

    rtc_stopwatch #(.W(SW_W)) u_sw (
        .clk(clk), .rst_n(rst_n), .load(sw_wr), .load_val(wdata[SW_W-1:0]),
        .step(ev_min), .count(sw_count), .armed(sw_armed), .fire(sw_fire)
    );

    // Compare the upcoming time with both alarm settings on each advance.
    always_comb begin
        al1_hit = adv && (nxt.hr == alm1.hr) && (nxt.min == alm1.min) &&
                  (nxt.sec == alm1.sec);
        al2_hit = adv && (nxt == alm2);
    end

    // Gather all event pulses into the status bit order.
    always_comb begin
        events         = '0;
        events[EV_SEC] = ev_sec;
        events[EV_MIN] = ev_min;
        events[EV_HR]  = ev_hr;
        events[EV_DAY] = ev_day;
        events[EV_AL1] = al1_hit;
        events[EV_AL2] = al2_hit;
        events[EV_SW]  = sw_fire;
    end

    // Hold alarm settings and interrupt enables written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm1 <= '0;
            alm2 <= '0;
            ien  <= '0;
        end else if (wr_en) begin
            case (sel)
                A_ALM1:  alm1 <= tod_t'(wdata[TOD_W-1:0]);
                A_ALM2:  alm2 <= tod_t'(wdata[TOD_W-1:0]);
                A_IEN:   ien  <= wdata[N_EV-1:0];
                default: ;
            endcase
        end
    end

    // Sticky status: new events set, software ones clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~(stat_wr ? wdata[N_EV-1:0] : '0)) | events;
    end

    // Return the addressed register word.
    always_comb begin
        case (sel)
            A_TIME:   rdata = DATA_W'(now);
            A_ALM1:   rdata = DATA_W'(alm1);
            A_ALM2:   rdata = DATA_W'(alm2);
            A_SWATCH: rdata = DATA_W'({sw_armed, sw_count});
            A_IEN:    rdata = DATA_W'(ien);
            A_ISTAT:  rdata = DATA_W'(stat);
            default:  rdata = '0;
        endcase
    end

    assign irq  = stat & ien;
    assign wake = |irq;

    // R7
    sticky_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat & $past(stat)) == $past(stat)));

    // R4
    alarm1_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (al1_hit && !wr_en) |=> ((now.hr == alm1.hr) && (now.min == alm1.min) &&
                                 (now.sec == alm1.sec)));

    // R5
    alarm2_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (al2_hit && !wr_en) |=> (now == alm2));
endmodule

// File: tb/rtc_core_test.sv
module rtc_core_test;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [6:0]  irq;
    logic        wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rtc_core #(.PRESCALE_DIV(DIV), .SW_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] tw(int d, int h, int m, int s);
        return {6'd0, 9'(d), 5'(h), 6'(m), 6'(s)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic test_reset();
        logic [31:0] v;
        rd(3'd0, v); check("R10 time", v, 0);
        rd(3'd5, v); check("R10 status", v, 0);
        rd(3'd4, v); check("R10 enable", v, 0);
        check("R10 irq", 32'(irq), 0);
        check("R10 wake", 32'(wake), 0);
    endtask

    task automatic test_second();
        logic [31:0] v;
        wr(3'd5, 32'h7f);
        wr(3'd0, tw(2, 3, 4, 5));
        rd(3'd0, v); check("R9 time readback", v, tw(2, 3, 4, 5));
        wait_cycles(DIV - 1);
        rd(3'd0, v); check("R1 no early advance", v, tw(2, 3, 4, 5));
        wait_cycles(1);
        rd(3'd0, v); check("R1 advance on period", v, tw(2, 3, 4, 6));
        rd(3'd5, v); check("R3 second bit", 32'(v[0]), 1);
        check("R3 no minute bit", 32'(v[1]), 0);
        wait_cycles(DIV);
        rd(3'd0, v); check("R1 second period", v, tw(2, 3, 4, 7));
    endtask

    task automatic test_cascade();
        logic [31:0] v;
        wr(3'd5, 32'h7f);
        wr(3'd0, tw(5, 23, 59, 59));
        wait_cycles(DIV);
        rd(3'd0, v); check("R2 day carry", v, tw(6, 0, 0, 0));
        rd(3'd5, v); check("R3 tick bits", 32'(v[3:0]), 32'hf);
        wr(3'd0, tw(364, 23, 59, 59));
        wait_cycles(DIV);
        rd(3'd0, v); check("R2 year wrap", v, tw(0, 0, 0, 0));
        wr(3'd0, tw(400, 30, 61, 62));
        rd(3'd0, v); check("R9 range clamp", v, 0);
    endtask

    task automatic test_alarm1();
        logic [31:0] v;
        wr(3'd1, tw(99, 10, 20, 30));
        wr(3'd5, 32'h7f);
        wr(3'd0, tw(3, 10, 20, 28));
        wait_cycles(DIV);
        rd(3'd5, v); check("R4 not yet", 32'(v[4]), 0);
        wait_cycles(DIV);
        rd(3'd5, v); check("R4 fires, day ignored", 32'(v[4]), 1);
        wr(3'd5, 32'h20);
        rd(3'd5, v); check("R7 other bit kept", 32'(v[4]), 1);
        wr(3'd4, 32'h0);
        check("R8 masked irq", 32'(irq), 0);
        check("R8 masked wake", 32'(wake), 0);
        wr(3'd4, 32'h10);
        check("R8 irq enabled", 32'(irq), 32'h10);
        check("R8 wake enabled", 32'(wake), 1);
        wr(3'd5, 32'h10);
        rd(3'd5, v); check("R7 clear", 32'(v[4]), 0);
        check("R8 wake cleared", 32'(wake), 0);
        wait_cycles(2 * DIV);
        rd(3'd5, v); check("R4 single event", 32'(v[4]), 0);
        wr(3'd4, 32'h0);
    endtask

    task automatic test_alarm2();
        logic [31:0] v;
        wr(3'd2, tw(7, 1, 2, 3));
        wr(3'd5, 32'h7f);
        wr(3'd0, tw(6, 1, 2, 2));
        wait_cycles(DIV);
        rd(3'd5, v); check("R5 wrong day", 32'(v[5]), 0);
        wr(3'd5, 32'h7f);
        wr(3'd0, tw(7, 1, 2, 2));
        wait_cycles(DIV);
        rd(3'd5, v); check("R5 full match", 32'(v[5]), 1);
    endtask

    task automatic test_stopwatch();
        logic [31:0] v;
        wr(3'd3, 32'd1);
        rd(3'd3, v); check("R6 armed load", v, 32'h1_0001);
        wr(3'd5, 32'h7f);
        wr(3'd0, tw(0, 0, 0, 58));
        wait_cycles(2 * DIV);
        rd(3'd3, v); check("R6 first decrement", v, 32'h1_0000);
        rd(3'd5, v); check("R6 no fire at zero", 32'(v[6]), 0);
        wait_cycles(59 * DIV);
        rd(3'd5, v); check("R6 no early fire", 32'(v[6]), 0);
        wait_cycles(DIV);
        rd(3'd5, v); check("R6 underflow fire", 32'(v[6]), 1);
        rd(3'd3, v); check("R6 disarmed", v, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        test_reset();
        test_second();
        test_cascade();
        test_alarm1();
        test_alarm2();
        test_stopwatch();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule